// File: doc/BRIEF.md
# Slope-Controlled Gate Drive Sequencer

This block decides, cycle by cycle, which gate current source drives a power MOSFET during switching. Turn-on runs three phases: a strong charge current up to the gate threshold, a weak charge current across the current-rise interval to hold down di/dt, and a strong charge current again so the drain voltage swing finishes quickly. Turn-off runs the same three steps in reverse order, using discharge sources. Each phase ends when a digital comparator flag reports the expected gate or drain condition. A per-phase timeout ends the phase anyway if that flag never arrives.

A fault request from the protection logic skips the slope-controlled steps and goes straight to strong full discharge. After every turn-off the block keeps the switch off for a minimum number of clock cycles, which gives the bootstrap capacitor time to recharge. While the switch rests off, the block enables a negative gate bias whenever the output-high-dv/dt comparator reports that the output has risen. This keeps the gate from being coupled on by a fast output edge.

Top module: `gdrv_slope_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all four current selects are low and the block is in the resting off state.
- R2: Turn-on begins with the strong charge select (`sel_hi_chg`) alone, and this lasts until `gate_above_vth` is sampled high.
- R3: The second turn-on phase drives the weak charge select (`sel_lo_chg`) alone until `gate_at_plateau` is sampled high. This phase is entered only from the first turn-on phase.
- R4: The third turn-on phase drives `sel_hi_chg` alone until `vds_low` is sampled high. The block then holds the fully-on state, in which no source is selected.
- R5: When `on_req` drops in the fully-on state, the block runs the turn-off phases in this order. First `sel_hi_dis` until `gate_at_plateau` is sampled low. Then `sel_lo_dis` until `gate_above_vth` is sampled low. Then `sel_hi_dis` for FULLDIS_CYC cycles. The block then enters the resting off state.
- R6: When `on_req` drops during a turn-on phase, the block enters the turn-off phase that mirrors it: phase 3 goes to the strong discharge before the plateau, phase 2 goes to the weak discharge, and phase 1 goes to the full discharge. `on_req` low takes priority over a flag sampled in the same cycle.
- R7: When `fast_off` is high in any turn-on phase, in the fully-on state, or in the first two turn-off phases, the next cycle drives full strong discharge (`sel_hi_dis`) directly. It takes priority over `on_req` and over every flag.
- R8: A phase that waits for a flag ends after PH_TIMEOUT cycles if that flag never arrives. The block then moves on as if the flag had come.
- R9: A new turn-on starts only after the block has spent at least MIN_OFF cycles in the resting off state. An earlier `on_req` is held back until then.
- R10: While `fast_off` is high, the block stays in the resting off state even when `on_req` is high.
- R11: `neg_bias_en` is high exactly when the block is in the resting off state and `out_above_lim` is high. This output is combinational from `out_above_lim`.
- R12: At most one of the four selects is high at any time, so a charge source and a discharge source are never selected together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Requested switch state (1 = on) |
| fast_off | input | 1 | Protection shutdown request |
| gate_above_vth | input | 1 | Gate voltage is above the MOSFET threshold |
| gate_at_plateau | input | 1 | Gate voltage is at or above the plateau level |
| vds_low | input | 1 | Drain-source voltage is below the fully-on limit |
| out_above_lim | input | 1 | Output voltage is above the high-dv/dt limit |
| sel_hi_chg | output | 1 | Strong gate charge source select |
| sel_lo_chg | output | 1 | Weak gate charge source select |
| sel_hi_dis | output | 1 | Strong gate discharge source select |
| sel_lo_dis | output | 1 | Weak gate discharge source select |
| neg_bias_en | output | 1 | Negative gate bias enable |

## Verification
Several events can land on the same clock edge, and the priority between them is what matters. The bench drops `on_req` and raises `fast_off` in the same cycle during the weak-charge phase. It also drops `on_req` in the same cycle that the threshold flag arrives during the first turn-on phase. A behavioural model in the bench applies the stated priority: fault, then off request, then flag or timeout. The bench compares every select against this model on every clock, so a wrong choice in any of these collisions shows up as a mismatch in the very next cycle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [2:0] {
        PH_REST    = 3'd0,
        PH_ON_FAST = 3'd1,
        PH_ON_SLOW = 3'd2,
        PH_ON_FIN  = 3'd3,
        PH_HOLD_ON = 3'd4,
        PH_OF_FAST = 3'd5,
        PH_OF_SLOW = 3'd6,
        PH_OF_FULL = 3'd7
    } gdrv_phase_e;

    typedef struct packed {
        gdrv_phase_e phase;
    } gdrv_seq_t;

endpackage

// File: rtl/gdrv_phase_timer.sv
module gdrv_phase_timer #(
    parameter int CNT_MAX = 255,
    localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (clr)              cnt_d = '0;
        else if (cnt_q == TOP) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gdrv_sel_decode.sv
module gdrv_sel_decode
    import gdrv_pkg::*;
(
    input  gdrv_phase_e phase,
    input  logic        out_above_lim,
    output logic        sel_hi_chg,
    output logic        sel_lo_chg,
    output logic        sel_hi_dis,
    output logic        sel_lo_dis,
    output logic        neg_bias_en
);
    always_comb begin
        sel_hi_chg  = 1'b0;
        sel_lo_chg  = 1'b0;
        sel_hi_dis  = 1'b0;
        sel_lo_dis  = 1'b0;
        neg_bias_en = 1'b0;
        unique case (phase)
            PH_ON_FAST, PH_ON_FIN:  sel_hi_chg = 1'b1;
            PH_ON_SLOW:             sel_lo_chg = 1'b1;
            PH_OF_FAST, PH_OF_FULL: sel_hi_dis = 1'b1;
            PH_OF_SLOW:             sel_lo_dis = 1'b1;
            PH_REST:                neg_bias_en = out_above_lim;
            default:                ;
        endcase
    end
endmodule

// File: rtl/gdrv_slope_seq.sv
module gdrv_slope_seq
    import gdrv_pkg::*;
#(
    parameter int MIN_OFF     = 250,
    parameter int PH_TIMEOUT  = 16,
    parameter int FULLDIS_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic fast_off,
    input  logic gate_above_vth,
    input  logic gate_at_plateau,
    input  logic vds_low,
    input  logic out_above_lim,
    output logic sel_hi_chg,
    output logic sel_lo_chg,
    output logic sel_hi_dis,
    output logic sel_lo_dis,
    output logic neg_bias_en
);
    localparam int MAX_A   = (MIN_OFF > PH_TIMEOUT) ? MIN_OFF : PH_TIMEOUT;
    localparam int CNT_MAX = (MAX_A > FULLDIS_CYC) ? MAX_A : FULLDIS_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(PH_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULLDIS_CYC - 1);
    localparam logic [CNT_W-1:0] REST_DONE = CNT_W'(MIN_OFF);

    gdrv_seq_t        seq_d, seq_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmo;
    logic             phase_chg;

    assign tmo       = (cnt_q == TMO_LAST);
    assign phase_chg = (seq_d.phase != seq_q.phase);

    gdrv_phase_timer #(.CNT_MAX(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_chg),
        .cnt_q (cnt_q)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_REST: begin
                if (on_req && !fast_off && cnt_q == REST_DONE)
                    seq_d.phase = PH_ON_FAST;
            end
            PH_ON_FAST: begin
                if (fast_off || !on_req)          seq_d.phase = PH_OF_FULL;
                else if (gate_above_vth || tmo)   seq_d.phase = PH_ON_SLOW;
            end
            PH_ON_SLOW: begin
                if (fast_off)                     seq_d.phase = PH_OF_FULL;
                else if (!on_req)                 seq_d.phase = PH_OF_SLOW;
                else if (gate_at_plateau || tmo)  seq_d.phase = PH_ON_FIN;
            end
            PH_ON_FIN: begin
                if (fast_off)                     seq_d.phase = PH_OF_FULL;
                else if (!on_req)                 seq_d.phase = PH_OF_FAST;
                else if (vds_low || tmo)          seq_d.phase = PH_HOLD_ON;
            end
            PH_HOLD_ON: begin
                if (fast_off)                     seq_d.phase = PH_OF_FULL;
                else if (!on_req)                 seq_d.phase = PH_OF_FAST;
            end
            PH_OF_FAST: begin
                if (fast_off)                     seq_d.phase = PH_OF_FULL;
                else if (!gate_at_plateau || tmo) seq_d.phase = PH_OF_SLOW;
            end
            PH_OF_SLOW: begin
                if (fast_off)                     seq_d.phase = PH_OF_FULL;
                else if (!gate_above_vth || tmo)  seq_d.phase = PH_OF_FULL;
            end
            PH_OF_FULL: begin
                if (cnt_q == FULL_LAST)           seq_d.phase = PH_REST;
            end
            default:                              seq_d.phase = PH_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_REST};
        else        seq_q <= seq_d;
    end

    gdrv_sel_decode u_dec (
        .phase         (seq_q.phase),
        .out_above_lim (out_above_lim),
        .sel_hi_chg    (sel_hi_chg),
        .sel_lo_chg    (sel_lo_chg),
        .sel_hi_dis    (sel_hi_dis),
        .sel_lo_dis    (sel_lo_dis),
        .neg_bias_en   (neg_bias_en)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_hi_chg, sel_lo_chg, sel_hi_dis, sel_lo_dis})); // R12

    AST_NEG_BIAS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        neg_bias_en |-> !(sel_hi_chg || sel_lo_chg || sel_hi_dis || sel_lo_dis)); // R11

    AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_off && (sel_hi_chg || sel_lo_chg || sel_lo_dis)) |=> sel_hi_dis); // R7

    AST_SLOW_AFTER_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ON_SLOW && $past(seq_q.phase) != PH_ON_SLOW)
            |-> $past(seq_q.phase) == PH_ON_FAST); // R3

    AST_MIRROR_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ON_SLOW && !on_req && !fast_off) |=> seq_q.phase == PH_OF_SLOW); // R6

    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase inside {PH_ON_FAST, PH_ON_SLOW, PH_ON_FIN, PH_OF_FAST, PH_OF_SLOW})
            |-> cnt_q < CNT_W'(PH_TIMEOUT)); // R8

    AST_MIN_OFF_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_ON_FAST && $past(seq_q.phase) == PH_REST)
            |-> $past(cnt_q) == REST_DONE); // R9
endmodule

// File: tb/gdrv_slope_seq_test.sv
module gdrv_slope_seq_test;
    localparam int MIN_OFF = 20;
    localparam int PHT     = 6;
    localparam int FD      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 1'b0, fast_off = 1'b0, vth = 1'b0, plat = 1'b0, vlow = 1'b0, olim = 1'b0;
    logic hc, lc, hd, ld, nb;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // model phases: 0 rest, 1..3 turn-on, 4 fully on, 5..7 turn-off
    int mph = 0;
    int mcnt = 0;

    always #4 clk = ~clk;

    gdrv_slope_seq #(.MIN_OFF(MIN_OFF), .PH_TIMEOUT(PHT), .FULLDIS_CYC(FD)) uut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .fast_off(fast_off),
        .gate_above_vth(vth), .gate_at_plateau(plat), .vds_low(vlow),
        .out_above_lim(olim), .sel_hi_chg(hc), .sel_lo_chg(lc),
        .sel_hi_dis(hd), .sel_lo_dis(ld), .neg_bias_en(nb));

    always @(posedge clk) begin
        int np;
        bit waited;
        if (!rst_n) begin
            mph = 0;
            mcnt = 0;
        end else begin
            np = mph;
            waited = (mcnt >= PHT - 1);
            if (mph == 0) begin
                if (on_req && !fast_off && mcnt >= MIN_OFF) np = 1;
            end else if (mph == 7) begin
                if (mcnt >= FD - 1) np = 0;
            end else if (fast_off) begin
                np = 7;
            end else if (mph >= 1 && mph <= 4 && !on_req) begin
                np = 8 - mph;
                if (mph == 4) np = 5;
            end else begin
                case (mph)
                    1: if (vth || waited) np = 2;
                    2: if (plat || waited) np = 3;
                    3: if (vlow || waited) np = 4;
                    5: if (!plat || waited) np = 6;
                    6: if (!vth || waited) np = 7;
                    default: ;
                endcase
            end
            if (np != mph) begin
                mph = np;
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        logic [4:0] exp_v, got_v;
        if (!done) begin
            exp_v = {mph == 1 || mph == 3, mph == 2, mph == 5 || mph == 7, mph == 6,
                     mph == 0 && olim};
            got_v = {hc, lc, hd, ld, nb};
            checks++;
            if (got_v !== exp_v) begin
                errors++;
                $display("FAIL %s: selects/bias actual=%b expected=%b (cycle %0d)",
                         tag, got_v, exp_v, cycles);
            end
            checks++;
            if ($countones({hc, lc, hd, ld}) > 1) begin
                errors++;
                $display("FAIL R12: select count actual=%0d expected<=1",
                         $countones({hc, lc, hd, ld}));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rest_all;
        on_req = 0; fast_off = 0; vth = 0; plat = 0; vlow = 0; olim = 0;
        cyc(MIN_OFF + 10);
    endtask

    initial begin
        tag = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        tag = "R10";
        on_req = 1; fast_off = 1;
        cyc(MIN_OFF + 8);
        fast_off = 0;

        tag = "R2";
        cyc(4);
        tag = "R3";
        vth = 1;
        cyc(3);
        tag = "R4";
        plat = 1;
        cyc(2);
        vlow = 1;
        cyc(4);

        tag = "R5";
        on_req = 0;
        cyc(2);
        olim = 1;
        vlow = 0;
        cyc(2);
        plat = 0;
        cyc(2);
        vth = 0;
        cyc(FD + 2);
        tag = "R11";
        cyc(3);
        olim = 0;
        cyc(2);
        olim = 1;
        cyc(1);
        olim = 0;

        tag = "R9";
        on_req = 1;
        cyc(MIN_OFF + 4);

        tag = "R8";
        cyc(3 * PHT + 4);

        tag = "R6";
        rest_all();
        on_req = 1;
        cyc(2);
        on_req = 0;
        cyc(FD + 2);
        rest_all();
        on_req = 1; vth = 1;
        cyc(3);
        on_req = 0;
        cyc(3);
        vth = 0;
        cyc(FD + 2);
        rest_all();
        on_req = 1; vth = 1; plat = 1;
        cyc(4);
        on_req = 0;
        cyc(PHT + 2);
        rest_all();
        on_req = 1;
        cyc(1);
        vth = 1; on_req = 0;
        cyc(FD + 3);

        tag = "R7";
        rest_all();
        on_req = 1; vth = 1; plat = 1; vlow = 1;
        cyc(6);
        fast_off = 1;
        cyc(2);
        fast_off = 0; on_req = 0;
        rest_all();
        on_req = 1; vth = 1;
        cyc(3);
        fast_off = 1; on_req = 0;
        cyc(2);
        fast_off = 0;
        rest_all();
        on_req = 1; vth = 1; plat = 1; vlow = 1;
        cyc(6);
        on_req = 0;
        cyc(1);
        fast_off = 1;
        cyc(FD + 2);
        rest_all();

        done = 1'b1;
        report();
    end
endmodule